// File: doc/BRIEF.md
# Flash command state machine

This block puts the host command interface of a byte-wide NOR flash in front of a small on-chip byte array. The array is split into equal sectors. The host drives chip enable, write enable, output enable, an address and a data byte, much as it would on a parallel memory bus. A write cycle counts at the clock edge where write enable returns high while chip enable is low. A read cycle counts at the edge where output enable falls while chip enable is low.

Commands are multi-write sequences, each opened by an unlock pair. The block decodes byte program, sector erase, chip erase, unlock bypass (two-write programming) and erase suspend/resume. Program and erase run as timed operations driven by counters. While an operation runs, reads return a status byte with a data-polling bit and a toggle bit. Each sector has a protection input, and a supply-inhibit input blocks all writes. A host reset input aborts the current operation. A separate power-on reset also sets the whole array to the erased value.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After power-on reset (`rst_ni` low) every array byte reads 0xFF, and reads with no operation running return array data.
- R2: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then D@A program byte A. The stored value becomes old AND D, so bits can only go from 1 to 0.
- R3: The prefix followed by 0x20@0x555 enters bypass mode. In bypass, 0xA0 at any address followed by D@A programs a byte. The pair 0x90 then 0x00 leaves bypass, after which the two-write form has no effect.
- R4: While an operation is busy, a read returns status. Bit 7 is the complement of bit 7 of the expected final data (the programmed byte, or 0xFF for erase). Bit 6 inverts on each read. Bits 5:0 are zero.
- R5: A program stays busy for exactly PROG_CYC clock edges after its data write. After that, reads return array data and new commands are accepted.
- R6: The prefix, 0x80@0x555, the prefix again and 0x30 at any address in a sector erase that sector. A preprogram phase of PRE_CYC edges sets the sector to 0x00. An erase phase of ERASE_CYC edges then sets it to 0xFF. Other sectors are unchanged.
- R7: The same sequence ending in 0x10@0x555 erases every unprotected sector.
- R8: A 0xB0 write during an erase suspends it with its timer held. Reads of sectors outside the erase return array data, and reads of erased sectors return status. Sectors outside the erase can be programmed. A 0x30 write resumes the erase and it completes.
- R9: A program or erase aimed at a sector whose `prot_i` bit is 1 leaves its contents unchanged and never shows busy status.
- R10: While `inhibit_i` is 1, every write cycle is ignored.
- R11: `host_rst_ni` low aborts any operation and bypass mode and returns to array read. Bytes already changed by a completed phase keep their new values.
- R12: A write that breaks the expected sequence returns to array read, so the full sequence must restart. Writes during a busy operation are ignored, except for 0xB0 during an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low; sets the array to 0xFF |
| host_rst_ni | input | 1 | Synchronous host reset, active low; aborts operations |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; a write counts on its rising edge |
| oe_ni | input | 1 | Output enable, active low; a read counts on its falling edge |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status; 0 when not enabled |
| inhibit_i | input | 1 | Low-supply write inhibit |
| prot_i | input | NSEC | Per-sector protection |

## Verification
A wrong decoder state shows up on the next write cycle. A later step of the sequence is then accepted or dropped, so the target byte reads back wrong once the program time has passed, or a busy status appears when none is expected. A wrong engine state or counter shows on the very next read: the status byte appears one edge too early or too late around the timing boundary, the data-polling or toggle bit is wrong, or a byte in an unrelated sector changes. The bench finds these by sweeping the whole array after each class of operation.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [10:0] UL_ADDR_A = 11'h555;
  localparam logic [10:0] UL_ADDR_B = 11'h2AA;

  localparam logic [7:0] CD_UNLK_A = 8'hAA;
  localparam logic [7:0] CD_UNLK_B = 8'h55;
  localparam logic [7:0] CD_PROG   = 8'hA0;
  localparam logic [7:0] CD_ERASE  = 8'h80;
  localparam logic [7:0] CD_SECTOR = 8'h30;
  localparam logic [7:0] CD_CHIP   = 8'h10;
  localparam logic [7:0] CD_BYP_IN = 8'h20;
  localparam logic [7:0] CD_BYP_X1 = 8'h90;
  localparam logic [7:0] CD_BYP_X2 = 8'h00;
  localparam logic [7:0] CD_SUSP   = 8'hB0;
  localparam logic [7:0] CD_RESUME = 8'h30;

  typedef enum logic [2:0] {
    SQ_READ, SQ_UL1, SQ_UL2, SQ_PGM, SQ_ER0, SQ_ER1, SQ_ER2, SQ_BEX
  } seq_e;

  typedef enum logic [2:0] {
    OP_IDLE, OP_PROG, OP_PRE, OP_ERASE, OP_SUSP, OP_SPROG
  } op_e;

  typedef struct packed {
    logic prog;
    logic serase;
    logic cerase;
    logic susp;
    logic resume;
  } cmd_t;
endpackage

// File: rtl/flash_bus_strobe.sv
module flash_bus_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  input  logic inhibit_i,
  output logic wr_stb_o,
  output logic rd_stb_o
);
  logic we_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni;
    end
  end

  // write counts on rising we, read on falling oe
  assign wr_stb_o = ~we_q & we_ni & ~ce_ni & ~inhibit_i;
  assign rd_stb_o = oe_q & ~oe_ni & ~ce_ni;
endmodule

// File: rtl/flash_seq_dec.sv
module flash_seq_dec
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rst_ni,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  input  logic              erase_run_i,
  input  logic              susp_i,
  output cmd_t              cmd_o
);
  seq_e st_q, st_d;
  logic byp_q, byp_d;
  logic at_a, at_b;

  assign at_a = (addr_i == ADDR_W'(UL_ADDR_A));
  assign at_b = (addr_i == ADDR_W'(UL_ADDR_B));

  always_comb begin
    st_d  = st_q;
    byp_d = byp_q;
    cmd_o = '0;
    if (wr_stb_i) begin
      if (busy_i) begin
        if (erase_run_i && data_i == CD_SUSP) cmd_o.susp = 1'b1;
      end else begin
        case (st_q)
          SQ_READ: begin
            if (susp_i && data_i == CD_RESUME) cmd_o.resume = 1'b1;
            else if (byp_q) begin
              if (data_i == CD_PROG) st_d = SQ_PGM;
              else if (data_i == CD_BYP_X1) st_d = SQ_BEX;
            end else if (data_i == CD_UNLK_A && at_a) st_d = SQ_UL1;
          end
          SQ_UL1: st_d = (data_i == CD_UNLK_B && at_b) ? SQ_UL2 : SQ_READ;
          SQ_UL2: begin
            st_d = SQ_READ;
            if (at_a) begin
              if (data_i == CD_PROG) st_d = SQ_PGM;
              else if (data_i == CD_ERASE) st_d = SQ_ER0;
              else if (data_i == CD_BYP_IN) byp_d = 1'b1;
            end
          end
          SQ_PGM: begin
            cmd_o.prog = 1'b1;
            st_d = SQ_READ;
          end
          SQ_ER0: st_d = (data_i == CD_UNLK_A && at_a) ? SQ_ER1 : SQ_READ;
          SQ_ER1: st_d = (data_i == CD_UNLK_B && at_b) ? SQ_ER2 : SQ_READ;
          SQ_ER2: begin
            st_d = SQ_READ;
            if (data_i == CD_SECTOR) cmd_o.serase = 1'b1;
            else if (data_i == CD_CHIP && at_a) cmd_o.cerase = 1'b1;
          end
          SQ_BEX: begin
            st_d = SQ_READ;
            if (data_i == CD_BYP_X2) byp_d = 1'b0;
          end
          default: st_d = SQ_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_READ;
      byp_q <= 1'b0;
    end else if (!host_rst_ni) begin
      st_q  <= SQ_READ;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      byp_q <= byp_d;
    end
  end

  // R12
  seq_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_UL1 && wr_stb_i && !busy_i && !(data_i == CD_UNLK_B && at_b))
    |=> st_q == SQ_READ);

  // R11
  host_rst_byp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rst_ni |=> (!byp_q && st_q == SQ_READ));
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 16,
  localparam int DEPTH    = NSEC * SEC_BYTES,
  localparam int IDX_W    = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             fill_en_i,
  input  logic [NSEC-1:0]  fill_mask_i,
  input  logic [7:0]       fill_val_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o
);
  logic [DEPTH*8-1:0] cells;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 8'hFF;
      else if (fill_en_i && fill_mask_i[g / SEC_BYTES]) q <= fill_val_i;
      else if (wr_en_i && wr_idx_i == IDX_W'(g)) q <= q & wr_data_i;
    end
    assign cells[g*8 +: 8] = q;
  end

  assign rd_data_o = cells[{rd_idx_i, 3'b000} +: 8];
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_cmd_pkg::*;
#(
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 16,
  parameter int PROG_CYC  = 20,
  parameter int PRE_CYC   = 30,
  parameter int ERASE_CYC = 40,
  localparam int SEC_W    = $clog2(NSEC),
  localparam int OFF_W    = $clog2(SEC_BYTES),
  localparam int IDX_W    = SEC_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_rst_ni,
  input  cmd_t             cmd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  input  logic [NSEC-1:0]  prot_i,
  input  logic             rd_stb_i,
  input  logic [SEC_W-1:0] rd_sec_i,
  output logic             busy_o,
  output logic             erase_run_o,
  output logic             susp_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             fill_en_o,
  output logic [NSEC-1:0]  fill_mask_o,
  output logic [7:0]       fill_val_o,
  output logic             status_sel_o,
  output logic [7:0]       status_o
);
  localparam int PC_W   = $clog2(PROG_CYC + 1);
  localparam int EC_MAX = (PRE_CYC > ERASE_CYC) ? PRE_CYC : ERASE_CYC;
  localparam int EC_W   = $clog2(EC_MAX + 1);

  op_e              st_q;
  logic             ph_q;
  logic [IDX_W-1:0] pidx_q;
  logic [7:0]       pdat_q;
  logic [NSEC-1:0]  mask_q;
  logic [PC_W-1:0]  pcnt_q;
  logic [EC_W-1:0]  ecnt_q;
  logic             tog_q;

  logic [SEC_W-1:0] cmd_sec;
  logic pdone, edone, prog_ok, susp_prog_ok, se_ok, ce_ok, prog_st, erase_st;

  assign cmd_sec      = idx_i[IDX_W-1:OFF_W];
  assign pdone        = (pcnt_q == '0);
  assign edone        = (ecnt_q == '0);
  assign prog_st      = (st_q == OP_PROG) || (st_q == OP_SPROG);
  assign erase_st     = (st_q == OP_PRE) || (st_q == OP_ERASE);
  assign prog_ok      = cmd_i.prog && !prot_i[cmd_sec];
  assign susp_prog_ok = prog_ok && !mask_q[cmd_sec];
  assign se_ok        = cmd_i.serase && !prot_i[cmd_sec];
  assign ce_ok        = cmd_i.cerase && (|(~prot_i));

  assign busy_o       = prog_st || erase_st;
  assign erase_run_o  = erase_st;
  assign susp_o       = (st_q == OP_SUSP);
  assign wr_en_o      = prog_st && pdone && host_rst_ni;
  assign wr_idx_o     = pidx_q;
  assign wr_data_o    = pdat_q;
  assign fill_en_o    = erase_st && edone && host_rst_ni;
  assign fill_mask_o  = mask_q;
  assign fill_val_o   = (st_q == OP_ERASE) ? 8'hFF : 8'h00;
  assign status_sel_o = busy_o || (susp_o && mask_q[rd_sec_i]);
  assign status_o     = {prog_st ? ~pdat_q[7] : 1'b0, tog_q, 6'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= OP_IDLE;
      ph_q   <= 1'b0;
      pidx_q <= '0;
      pdat_q <= '0;
      mask_q <= '0;
      pcnt_q <= '0;
      ecnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (!host_rst_ni) begin
      st_q   <= OP_IDLE;
      mask_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (rd_stb_i && status_sel_o) tog_q <= ~tog_q;
      case (st_q)
        OP_IDLE: begin
          if (prog_ok) begin
            st_q   <= OP_PROG;
            pidx_q <= idx_i;
            pdat_q <= data_i;
            pcnt_q <= PC_W'(PROG_CYC - 1);
          end else if (se_ok || ce_ok) begin
            st_q   <= OP_PRE;
            mask_q <= se_ok ? (NSEC'(1) << cmd_sec) : ~prot_i;
            ecnt_q <= EC_W'(PRE_CYC - 1);
          end
        end
        OP_PROG: begin
          if (pdone) st_q <= OP_IDLE;
          else pcnt_q <= pcnt_q - 1'b1;
        end
        OP_PRE: begin
          if (cmd_i.susp) begin
            st_q <= OP_SUSP;
            ph_q <= 1'b0;
          end else if (edone) begin
            st_q   <= OP_ERASE;
            ecnt_q <= EC_W'(ERASE_CYC - 1);
          end else ecnt_q <= ecnt_q - 1'b1;
        end
        OP_ERASE: begin
          if (cmd_i.susp) begin
            st_q <= OP_SUSP;
            ph_q <= 1'b1;
          end else if (edone) begin
            st_q   <= OP_IDLE;
            mask_q <= '0;
          end else ecnt_q <= ecnt_q - 1'b1;
        end
        OP_SUSP: begin
          if (cmd_i.resume) st_q <= ph_q ? OP_ERASE : OP_PRE;
          else if (susp_prog_ok) begin
            st_q   <= OP_SPROG;
            pidx_q <= idx_i;
            pdat_q <= data_i;
            pcnt_q <= PC_W'(PROG_CYC - 1);
          end
        end
        OP_SPROG: begin
          if (pdone) st_q <= OP_SUSP;
          else pcnt_q <= pcnt_q - 1'b1;
        end
        default: st_q <= OP_IDLE;
      endcase
    end
  end

  // R5
  prog_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OP_PROG && pdone) |=> st_q == OP_IDLE);

  // R9
  prot_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OP_IDLE && (cmd_i.prog || cmd_i.serase) && prot_i[cmd_sec]) |=> st_q == OP_IDLE);

  // R11
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rst_ni |=> st_q == OP_IDLE);

  // R8
  susp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == OP_SUSP) |=> $stable(ecnt_q));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int NSEC      = 8,
  parameter int SEC_BYTES = 16,
  parameter int PROG_CYC  = 20,
  parameter int PRE_CYC   = 30,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  input  logic              inhibit_i,
  input  logic [NSEC-1:0]   prot_i
);
  localparam int SEC_W = $clog2(NSEC);
  localparam int OFF_W = $clog2(SEC_BYTES);
  localparam int IDX_W = SEC_W + OFF_W;

  logic wr_stb, rd_stb, busy, erase_run, susp;
  cmd_t cmd;
  logic wr_en, fill_en, status_sel;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data, fill_val, status, arr_rd;
  logic [NSEC-1:0] fill_mask;

  flash_bus_strobe u_strobe (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .inhibit_i,
    .wr_stb_o(wr_stb), .rd_stb_o(rd_stb)
  );

  flash_seq_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .host_rst_ni,
    .wr_stb_i(wr_stb), .addr_i, .data_i,
    .busy_i(busy), .erase_run_i(erase_run), .susp_i(susp),
    .cmd_o(cmd)
  );

  flash_op_engine #(
    .NSEC(NSEC), .SEC_BYTES(SEC_BYTES),
    .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk_i, .rst_ni, .host_rst_ni,
    .cmd_i(cmd), .idx_i(addr_i[IDX_W-1:0]), .data_i, .prot_i,
    .rd_stb_i(rd_stb), .rd_sec_i(addr_i[IDX_W-1:OFF_W]),
    .busy_o(busy), .erase_run_o(erase_run), .susp_o(susp),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .fill_en_o(fill_en), .fill_mask_o(fill_mask), .fill_val_o(fill_val),
    .status_sel_o(status_sel), .status_o(status)
  );

  flash_array #(.NSEC(NSEC), .SEC_BYTES(SEC_BYTES)) u_arr (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .fill_en_i(fill_en), .fill_mask_i(fill_mask), .fill_val_i(fill_val),
    .rd_idx_i(addr_i[IDX_W-1:0]), .rd_data_o(arr_rd)
  );

  assign data_o = (!ce_ni && !oe_ni) ? (status_sel ? status : arr_rd) : 8'h00;

  // R10
  inhibit_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> cmd == '0);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int AW = 11, NS = 8, SB = 16, PC = 20, PRE = 30, ER = 40;
  localparam int DEPTH = NS * SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0, host_rst_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, inhibit = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [NS-1:0] prot = '0;

  logic [7:0] exp_mem [DEPTH];
  logic [7:0] v, v1, v2;
  int cyc = 0, n_cmp = 0, n_bad = 0, t0, ts, tr, remain;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_cmd_ctrl #(.ADDR_W(AW), .NSEC(NS), .SEC_BYTES(SB),
    .PROG_CYC(PC), .PRE_CYC(PRE), .ERASE_CYC(ER)) u_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .host_rst_ni(host_rst_n),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n), .addr_i(addr),
    .data_i(din), .data_o(dout), .inhibit_i(inhibit), .prot_i(prot));

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; addr = a; din = d;
    @(posedge clk); @(negedge clk);
    we_n = 1'b1;
    @(posedge clk); @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    ce_n = 1'b0; oe_n = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic prefix();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic prog4(input logic [AW-1:0] a, input logic [7:0] d);
    prefix(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_seq(input logic [AW-1:0] a, input logic [7:0] code);
    prefix(); wr(11'h555, 8'h80); prefix(); wr(a, code);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] r;
      rd(AW'(i), r);
      chk(req, r, exp_mem[i]);
    end
  endtask

  task automatic fill_model(input int sec, input logic [7:0] val);
    for (int i = 0; i < SB; i++) exp_mem[sec*SB + i] = val;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(11'h000, v);
    chk("R1 first read", v, 8'hFF);
    sweep("R1 erased array");

    // R2 / R4 / R5: four-write program, status, busy window
    prog4(11'h013, 8'h5A); t0 = cyc;
    exp_mem[8'h13] &= 8'h5A;
    rd(11'h013, v1);
    chk("R4 poll bit program", v1 & 8'hBF, 8'h80);
    rd(11'h013, v2);
    chk("R4 toggle", {7'b0, v2[6]}, {7'b0, ~v1[6]});
    wait_to(t0 + PC - 2);
    rd(11'h013, v);
    chk("R5 still busy last edge", v & 8'hBF, 8'h80);
    @(negedge clk);
    prog4(11'h027, 8'hC3); t0 = cyc;
    exp_mem[8'h27] &= 8'hC3;
    rd(11'h027, v);
    chk("R4 poll bit zero", v & 8'hBF, 8'h00);
    wait_to(t0 + PC - 1);
    rd(11'h027, v);
    chk("R5 done at PROG_CYC", v, exp_mem[8'h27]);
    rd(11'h013, v);
    chk("R2 programmed byte", v, exp_mem[8'h13]);
    prog4(11'h013, 8'hF0); t0 = cyc;
    exp_mem[8'h13] &= 8'hF0;
    wait_to(t0 + PC + 2);
    rd(11'h013, v);
    chk("R2 AND semantics", v, exp_mem[8'h13]);

    // R12: writes while busy are ignored
    prog4(11'h040, 8'h00); t0 = cyc;
    exp_mem[8'h40] = 8'h00;
    prog4(11'h041, 8'h00);
    wait_to(t0 + PC + 4);
    rd(11'h040, v); chk("R12 first program", v, 8'h00);
    rd(11'h041, v); chk("R12 busy write ignored", v, 8'hFF);

    // R12: broken sequences
    prefix(); wr(11'h555, 8'h77); wr(11'h042, 8'h00);
    wr(11'h555, 8'hAA); wr(11'h123, 8'h55); wr(11'h555, 8'hA0); wr(11'h043, 8'h00);
    rd(11'h042, v); chk("R12 wrong code", v, 8'hFF);
    rd(11'h043, v); chk("R12 wrong address", v, 8'hFF);
    prog4(11'h044, 8'h0F); t0 = cyc;
    exp_mem[8'h44] = 8'h0F;
    wait_to(t0 + PC + 2);
    rd(11'h044, v); chk("R12 restart works", v, 8'h0F);

    // R3: bypass
    prefix(); wr(11'h555, 8'h20);
    wr(11'h000, 8'hA0); wr(11'h050, 8'h81); t0 = cyc;
    exp_mem[8'h50] = 8'h81;
    rd(11'h050, v); chk("R3 bypass program busy", v & 8'hBF, 8'h00);
    wait_to(t0 + PC + 2);
    rd(11'h050, v); chk("R3 bypass program", v, 8'h81);
    wr(11'h000, 8'h90); wr(11'h000, 8'h00);
    wr(11'h000, 8'hA0); wr(11'h051, 8'h00);
    rd(11'h051, v); chk("R3 bypass left", v, 8'hFF);

    // R6: sector erase
    erase_seq(11'h01C, 8'h30); t0 = cyc;
    rd(11'h013, v); chk("R4 erase poll", v & 8'hBF, 8'h00);
    wait_to(t0 + PRE + ER - 2);
    rd(11'h013, v); chk("R6 busy at end", v & 8'hBF, 8'h00);
    rd(11'h013, v); chk("R6 erased", v, 8'hFF);
    fill_model(1, 8'hFF);
    sweep("R6 sector erase");

    // R11: abort after preprogram, and bypass cleared
    prog4(11'h055, 8'hA5); t0 = cyc;
    wait_to(t0 + PC + 2);
    erase_seq(11'h050, 8'h30); t0 = cyc;
    wait_to(t0 + PRE + 3);
    host_rst_n = 1'b0; @(negedge clk); host_rst_n = 1'b1;
    fill_model(5, 8'h00);
    rd(11'h055, v); chk("R11 abort keeps preprogram", v, 8'h00);
    rd(11'h05F, v); chk("R11 read mode after abort", v, 8'h00);
    prefix(); wr(11'h555, 8'h20);
    host_rst_n = 1'b0; @(negedge clk); host_rst_n = 1'b1;
    wr(11'h000, 8'hA0); wr(11'h060, 8'h00);
    rd(11'h060, v); chk("R11 bypass cleared", v, 8'hFF);

    // R8: suspend / resume
    prog4(11'h022, 8'h33); t0 = cyc;
    wait_to(t0 + PC + 2);
    exp_mem[8'h22] = 8'h33;
    erase_seq(11'h020, 8'h30); t0 = cyc;
    wait_to(t0 + 5);
    wr(11'h000, 8'hB0); ts = cyc;
    rd(11'h005, v); chk("R8 other sector readable", v, exp_mem[8'h05]);
    rd(11'h022, v); chk("R8 erasing sector status", v & 8'hBF, 8'h00);
    prog4(11'h007, 8'h12); t0 = cyc;
    exp_mem[8'h07] &= 8'h12;
    wait_to(t0 + PC + 2);
    rd(11'h007, v); chk("R8 program in suspend", v, exp_mem[8'h07]);
    wr(11'h000, 8'h30); tr = cyc;
    remain = PRE + ER - (ts - (ts - 5 - 10));
    remain = PRE + ER - 5 - 10;
    rd(11'h022, v); chk("R8 resumed busy", v & 8'h80, 8'h00);
    wait_to(tr + remain - 3);
    rd(11'h022, v); chk("R8 timer held in suspend", v & 8'h80, 8'h00);
    wait_to(tr + PRE + ER + 2);
    fill_model(2, 8'hFF);
    rd(11'h022, v); chk("R8 erase completed", v, 8'hFF);

    // R9 / R7: protection and chip erase
    prog4(11'h075, 8'h11); t0 = cyc; wait_to(t0 + PC + 2);
    prog4(11'h035, 8'h22); t0 = cyc; wait_to(t0 + PC + 2);
    exp_mem[8'h75] = 8'h11; exp_mem[8'h35] = 8'h22;
    prot = 8'h80;
    prog4(11'h076, 8'h00);
    rd(11'h076, v); chk("R9 protected program", v, 8'hFF);
    erase_seq(11'h070, 8'h30);
    rd(11'h075, v); chk("R9 protected erase", v, 8'h11);
    erase_seq(11'h555, 8'h10); t0 = cyc;
    wait_to(t0 + PRE + ER + 2);
    for (int s = 0; s < NS - 1; s++) fill_model(s, 8'hFF);
    sweep("R7 chip erase");
    prot = '0;

    // R10: inhibit
    inhibit = 1'b1;
    prog4(11'h035, 8'h00);
    rd(11'h035, v); chk("R10 inhibited program", v, 8'hFF);
    erase_seq(11'h075, 8'h30);
    rd(11'h075, v); chk("R10 inhibited erase", v, 8'h11);
    inhibit = 1'b0;
    sweep("R10 array intact");

    finish_run();
  end
endmodule